// File: doc/BRIEF.md
# Packed-Lane Add/Subtract Unit with Saturation

This block does add and subtract work on one 32-bit word, with the word split into lanes. The lanes can be four unsigned bytes, two halfwords read as signed or as unsigned, or a single signed word. Every lane is computed in parallel. The result is registered one cycle after a valid request. The operations are:

- plain (wrapping) add and subtract;
- add and subtract that clamp at the lane's range limits;
- halving add and subtract, each with or without rounding;
- a clamped absolute value.

A 32-bit status register is kept beside the datapath. Any lane overflow from an add, a subtract or an absolute value sets bit 20 of this register. The bit stays set until software writes the register. The other fields stay as software last wrote them: a carry bit at bit 13 and a 6-bit position field in bits 5..0.

The unit is meant to sit in the execute stage of a core. The decoder presents an operation code and two operands with a valid strobe. The register-write path of the core uses the status write port to load or clear the status word.

Top module: `lane_arith_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `result` and `status` to zero.
- R2: `op[5:4]` selects the lane format: 0 = four unsigned bytes, 1 = two signed halfwords, 2 = two unsigned halfwords, 3 = one signed word. With `op[3:0]` = 0 (add) or 1 (subtract), each lane gets its low N bits of a+b or a-b. A lane overflows in these cases:
  - unsigned lanes: on carry-out or borrow;
  - signed lanes: when bits N and N-1 of the sign-extended (N+1)-bit result differ.
- R3: With `op[3:0]` = 2 (add) or 3 (subtract) on a signed format, an overflowing lane clamps to its most positive value when the extra top bit of the (N+1)-bit result is 0. It clamps to its most negative value when that bit is 1. A lane that does not overflow is exact.
- R4: With `op[3:0]` = 2 or 3 on an unsigned format, a lane whose add carries out becomes all ones. A lane whose subtract borrows becomes zero. Other lanes are exact.
- R5: `op[3:0]` selects the halving operations:
  - 4: halving add;
  - 5: halving subtract;
  - 6: rounding halving add;
  - 7: rounding halving subtract.

  Each forms the full (N+1)-bit sum or difference, adds 1 for the rounding codes, and shifts right by one (arithmetic shift for signed formats). These operations never set the overflow bit.
- R6: `op[3:0]` = 8 is the absolute value, with each lane read as signed in every format. The most negative lane value gives the most positive value and counts as an overflow. Any other negative value is negated, and non-negative values pass through unchanged.
- R7: A lane overflow under R2, R3, R4 or R6 sets `status[20]`. The bit stays set across later requests and is cleared only by a status write.
- R8: A status write loads the whole of `stat_wdata` into `status`. If an overflowing request is accepted in the same cycle, bit 20 is still set on top of the written value. Without a write, requests change no status bit other than bit 20, so the carry bit 13 and the position field 5..0 keep their value.
- R9: A request with `in_valid` high and `op[3:0]` in 0..8 updates `result` at the next rising edge. When `in_valid` is low, or `op[3:0]` is 9..15, `result` holds and no status bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe for `op`, `a`, `b` |
| op | input | 6 | Lane format in [5:4], operation kind in [3:0] |
| a | input | 32 | First operand word |
| b | input | 32 | Second operand word (subtrahend for subtract) |
| stat_wr | input | 1 | Status write enable |
| stat_wdata | input | 32 | Value loaded into the status register |
| result | output | 32 | Registered lane results |
| status | output | 32 | Status register: sticky overflow bit 20, carry bit 13, position 5..0 |

## Verification
The bench sweeps every format and kind over lane operands drawn from the range edges: zero, one, the largest positive value, the most negative value and its neighbour, all ones less one, all ones, and a quarter-scale value. Different lanes get different pairs, and random words are added on top.

The bench targets these faults and how they would show:
- Saturation keyed to the wrong sign bit returns the opposite limit, for example 0x8000 for 0x7FFF+1.
- An unsigned subtract that does not clamp on borrow wraps to large values.
- Rounding applied before widening loses the carry on 0xFF+0xFF.
- A wrong absolute value of the most negative value returns that same value, or leaves the overflow bit clear.
- A sticky bit handled wrongly is cleared by a quiet halving request, or drops the overflow raised in the same cycle as a status write.

// File: rtl/lane_arith_unit.sv
module lane_arith_unit #(
  parameter int OVF_BIT = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [5:0]  op,
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic        stat_wr,
  input  logic [31:0] stat_wdata,
  output logic [31:0] result,
  output logic [31:0] status
);

  localparam int WORD   = 32;
  localparam int BYTES  = WORD / 8;
  localparam int HALVES = WORD / 16;
  localparam logic [3:0] LAST_KIND = 4'd8;

  // kind: 0 add, 1 sub, 2 sat add, 3 sat sub, 4 hadd, 5 hsub,
  //       6 rounding hadd, 7 rounding hsub, 8 sat abs
  function automatic logic [32:0] lane_fn(input logic [31:0] x, input logic [31:0] y,
                                          input int w, input logic [3:0] kind,
                                          input logic sgn);
    logic [33:0] msk, xe, ye, s, t;
    logic [31:0] mx, mn, r;
    logic ovf, xneg;
    msk  = (34'd1 << w) - 34'd1;
    xneg = x[w-1];
    xe   = {2'b00, x} & msk;
    ye   = {2'b00, y} & msk;
    if (sgn && xneg)   xe = xe | ~msk;
    if (sgn && y[w-1]) ye = ye | ~msk;
    s   = kind[0] ? xe - ye : xe + ye;
    t   = s + {33'd0, kind[1]};
    ovf = sgn ? (s[w] ^ s[w-1]) : s[w];
    mx  = sgn ? msk[32:1] : msk[31:0];
    mn  = 32'd1 << (w - 1);
    r   = s[31:0];
    if (kind[3]) begin
      ovf = xneg && (x == mn);
      if (ovf)       r = msk[32:1];
      else if (xneg) r = 32'd0 - x;
      else           r = x;
    end else if (kind[2]) begin
      r   = t[32:1];
      ovf = 1'b0;
    end else if (kind[1] && ovf) begin
      r = sgn ? (s[w] ? mn : mx) : (kind[0] ? 32'd0 : mx);
    end
    return {ovf, r & msk[31:0]};
  endfunction

  logic [1:0]  fmt;
  logic [3:0]  kind;
  logic        op_ok;
  logic [31:0] res_b, res_h, res_w, res_sel;
  logic [BYTES-1:0]  ovf_b;
  logic [HALVES-1:0] ovf_h;
  logic        ovf_w, ovf_sel;
  logic [31:0] res_q, stat_q;

  assign fmt   = op[5:4];
  assign kind  = op[3:0];
  assign op_ok = kind <= LAST_KIND;

  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    logic [32:0] lo;
    logic [23:0] unused_hi;
    assign lo = lane_fn({24'd0, a[8*i +: 8]}, {24'd0, b[8*i +: 8]}, 8, kind, 1'b0);
    assign res_b[8*i +: 8] = lo[7:0];
    assign ovf_b[i]        = lo[32];
    assign unused_hi       = lo[31:8];
  end

  for (genvar i = 0; i < HALVES; i++) begin : g_half
    logic [32:0] lo;
    logic [15:0] unused_hi;
    assign lo = lane_fn({16'd0, a[16*i +: 16]}, {16'd0, b[16*i +: 16]}, 16, kind,
                        fmt == 2'd1);
    assign res_h[16*i +: 16] = lo[15:0];
    assign ovf_h[i]          = lo[32];
    assign unused_hi         = lo[31:16];
  end

  assign {ovf_w, res_w} = lane_fn(a, b, 32, kind, 1'b1);

  always_comb begin
    case (fmt)
      2'd0:    begin res_sel = res_b; ovf_sel = |ovf_b; end
      2'd3:    begin res_sel = res_w; ovf_sel = ovf_w;  end
      default: begin res_sel = res_h; ovf_sel = |ovf_h; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      stat_q <= '0;
    end else begin
      if (stat_wr) stat_q <= stat_wdata;
      if (in_valid && op_ok) begin
        res_q <= res_sel;
        if (ovf_sel) stat_q[OVF_BIT] <= 1'b1;
      end
    end
  end

  assign result = res_q;
  assign status = stat_q;

endmodule

// File: rtl/lane_arith_unit_chk.sv
module lane_arith_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [5:0]  op,
  input logic [31:0] a,
  input logic        stat_wr,
  input logic [31:0] stat_wdata,
  input logic [31:0] result,
  input logic [31:0] status
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (status == 32'd0 && result == 32'd0));

  p_adds_ceiling_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 6'h02) |=> result[7:0] >= $past(a[7:0]));

  p_subs_floor_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 6'h03) |=> result[7:0] <= $past(a[7:0]));

  p_halving_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !stat_wr && !status[20] && op[3:2] == 2'b01) |=> !status[20]);

  p_abs_nonneg_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 6'h38) |=> !result[31]);

  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!stat_wr && status[20]) |=> status[20]);

  p_other_bits_r8: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> ($stable(status[31:21]) && $stable(status[19:0])));

  p_write_load_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !in_valid) |=> status == $past(stat_wdata));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

endmodule

bind lane_arith_unit lane_arith_unit_chk chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .a(a),
  .stat_wr(stat_wr), .stat_wdata(stat_wdata), .result(result), .status(status)
);

// File: tb/lane_arith_unit_tb_top.sv
`timescale 1ns/1ps
module lane_arith_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [5:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        stat_wr = 1'b0;
  logic [31:0] stat_wdata = '0;
  logic [31:0] result, status;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  localparam logic [31:0] BASE_ST = 32'h0000_2015;

  lane_arith_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .result(result), .status(status)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic longint ref_lane(input longint x, input longint y, input int w,
                                      input int kind, input bit sgn, output bit ovf);
    longint umax, smax, smin, half, xv, yv, s, r;
    umax = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    smax = half - 1;
    smin = -half;
    xv = (sgn && x >= half) ? x - (umax + 1) : x;
    yv = (sgn && y >= half) ? y - (umax + 1) : y;
    ovf = 1'b0;
    r = 0;
    if (kind <= 3) begin
      s = (kind % 2) ? xv - yv : xv + yv;
      ovf = sgn ? (s > smax || s < smin) : (s < 0 || s > umax);
      r = s;
      if (kind >= 2 && ovf) r = sgn ? ((s > smax) ? smax : smin) : ((kind == 2) ? umax : 0);
    end else if (kind <= 7) begin
      s = (kind % 2) ? xv - yv : xv + yv;
      if (kind >= 6) s = s + 1;
      r = s >>> 1;
    end else begin
      xv = (x >= half) ? x - (umax + 1) : x;
      if (xv == smin) begin r = smax; ovf = 1'b1; end
      else r = (xv < 0) ? -xv : xv;
    end
    return r & umax;
  endfunction

  function automatic longint corner(input int w, input int idx);
    longint umax, half;
    umax = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    case (idx)
      0: return 0;
      1: return 1;
      2: return half - 1;
      3: return half;
      4: return half + 1;
      5: return umax - 1;
      6: return umax;
      default: return half >> 1;
    endcase
  endfunction

  function automatic string tag_of(input int kind, input bit sgn);
    if (kind <= 1) return "R2";
    if (kind <= 3) return sgn ? "R3" : "R4";
    if (kind <= 7) return "R5";
    return "R6";
  endfunction

  task automatic run_op(input int fmt, input int kind, input logic [31:0] av,
                        input logic [31:0] bv);
    int w, n;
    bit sgn, ov, any_ov;
    longint ex, x, y, umax;
    w = (fmt == 0) ? 8 : (fmt == 3) ? 32 : 16;
    n = 32 / w;
    sgn = (fmt == 1 || fmt == 3);
    umax = (longint'(1) << w) - 1;
    ex = 0;
    any_ov = 1'b0;
    for (int k = 0; k < n; k++) begin
      x = (longint'(av) >> (k * w)) & umax;
      y = (longint'(bv) >> (k * w)) & umax;
      ex = ex | (ref_lane(x, y, w, kind, sgn, ov) << (k * w));
      any_ov = any_ov | ov;
    end
    @(negedge clk);
    stat_wr = 1'b1; stat_wdata = BASE_ST; in_valid = 1'b0;
    @(negedge clk);
    stat_wr = 1'b0; in_valid = 1'b1;
    op = {2'(fmt), 4'(kind)}; a = av; b = bv;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag_of(kind, sgn), result, ex[31:0]);
    check("R7", status, BASE_ST | (32'(any_ov) << 20));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] av, bv, held;
    int w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 result", result, 32'd0);
    check("R1 status", status, 32'd0);

    for (int fmt = 0; fmt < 4; fmt++) begin
      w = (fmt == 0) ? 8 : (fmt == 3) ? 32 : 16;
      for (int kind = 0; kind <= 8; kind++) begin
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 8; j++) begin
            av = '0; bv = '0;
            for (int k = 0; k < 32 / w; k++) begin
              av = av | 32'(corner(w, (i + k) % 8) << (k * w));
              bv = bv | 32'(corner(w, (j + 3 * k) % 8) << (k * w));
            end
            run_op(fmt, kind, av, bv);
          end
        end
        for (int r = 0; r < 24; r++) run_op(fmt, kind, $urandom, $urandom);
      end
    end

    // R7: sticky bit survives a quiet request, then a write clears it
    run_op(0, 2, 32'h0000_00FF, 32'h0000_0001);
    @(negedge clk);
    in_valid = 1'b1; op = 6'h14; a = 32'h0000_0000; b = 32'h0000_0000;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 sticky kept", status, BASE_ST | 32'h0010_0000);
    check("R5 quiet result", result, 32'd0);
    stat_wr = 1'b1; stat_wdata = 32'd0;
    @(negedge clk);
    stat_wr = 1'b0;
    check("R7 cleared by write", status, 32'd0);

    // R8: write and overflow in the same cycle
    stat_wr = 1'b1; stat_wdata = 32'h0000_3F2A;
    in_valid = 1'b1; op = 6'h32; a = 32'h7FFF_FFFF; b = 32'h0000_0001;
    @(negedge clk);
    stat_wr = 1'b0; in_valid = 1'b0;
    check("R8 merged status", status, 32'h0010_3F2A);
    check("R3 word clamp", result, 32'h7FFF_FFFF);

    // R9: reserved kind and idle cycles leave result and status alone
    held = result;
    in_valid = 1'b1; op = 6'h09; a = 32'h8000_0000; b = 32'h8000_0000;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 reserved result", result, held);
    check("R9 reserved status", status, 32'h0010_3F2A);
    op = 6'h00; a = 32'h1111_1111; b = 32'h2222_2222;
    @(negedge clk);
    check("R9 idle result", result, held);
    check("R8 bits held", status, 32'h0010_3F2A);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule